// File: doc/BRIEF.md
# Pattern-Based SDRAM Command Sequencer

This block is the command back-end of a memory controller whose timing must be bounded. It never schedules single commands. Each request it accepts is served by running one of five fixed command patterns: read access, write access, read-to-write turnaround, write-to-read turnaround, and refresh. Each pattern lasts a known, constant number of cycles, so the cycle cost of any request depends only on its direction and on the pattern that ran before it.

An access pattern visits every bank in ascending order. Each bank gets an activate, a fixed number of bursts to one row, and a precharge. No bank stays open once its slot ends, so no row state carries from one request to the next. A turnaround pattern is a run of idle cycles. It is placed before an access only when the data direction changes. A refresh timer raises a due flag after a set number of cycles. That flag is served at the next pattern boundary, between requests, and never cuts a pattern short.

Requests arrive on a valid/ready handshake. `req_ready` is high only at a pattern boundary: while no pattern runs, or in the last cycle of a pattern. It is also held low while a refresh is due and while an accepted request waits behind its turnaround. A requester that sees `req_ready` low must keep `req_valid` and the request fields stable until a cycle with both high. That cycle is the transfer. The first command of the chosen pattern appears in the next cycle.

Top module: `sdram_pattern_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd` is NOP (0), `pat_done` is low and `req_ready` is high.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. An access pattern lasts NUM_BANKS*SLOT cycles, where SLOT = T_RCD + (BURSTS-1)*BURST_GAP + T_TAIL + 1. Bank b takes cycles b*SLOT to b*SLOT+SLOT-1. At slot offset 0 it receives ACT with `cmd_addr` equal to the row. At offset T_RCD + k*BURST_GAP, for k = 0 to BURSTS-1, it receives RD or WR with `cmd_addr` equal to the start column plus k*BURST_LEN, wrapped modulo 2^COL_W. At offset SLOT-1 it receives PRE. All other cycles are NOP, and `cmd_bank` is 0 on NOP and REF.
- R3: A request in the same direction as the previous access, with no refresh due, is accepted in the last cycle of that access. Its ACT appears in the very next cycle.
- R4: A write after a read access is preceded by a turnaround of R2W_LEN NOP cycles. A read after a write access is preceded by a turnaround of W2R_LEN NOP cycles. The access starts in the cycle after the turnaround ends, and a RD never comes less than W2R_LEN cycles after a WR, nor a WR less than R2W_LEN cycles after a RD.
- R5: A refresh pattern is a REF followed by NOPs, REF_LEN cycles in all, and is issued only when every bank is closed. With no requests, REF commands recur every REF_INTERVAL+1 cycles.
- R6: After reset or after a refresh pattern, an access in either direction starts with no turnaround.
- R7: `req_ready` is low in every cycle of a pattern except its last. It is also low while a refresh is due and while an accepted request waits behind its turnaround. No bank is left open when a request is accepted.
- R8: `pat_done` is a one-cycle pulse in the last cycle of every pattern.
- R9: ACT goes only to a closed bank, and PRE only to an open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid is also high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_row | input | ROW_W | Row opened in every bank |
| req_col | input | COL_W | Start column of the first burst |
| cmd | output | 3 | Command code (NOP, ACT, RD, WR, PRE, REF) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR, else 0 |
| pat_done | output | 1 | Last cycle of the running pattern |

## Verification
A table of eight requests walks through runs of reads, runs of writes, and alternations. Direction changes show that a turnaround of the right length is inserted, and repeats show that the next access follows back to back with no gap. One request starts near the top of the column space, so the second burst's column must wrap. This catches a column computed at the wrong width. The refresh timer fires during the table, which shows that a refresh between two opposite-direction requests removes the need for a turnaround. A long idle stretch then measures the refresh period and the refresh pattern's length.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    PAT_READ    = 3'd0,
    PAT_WRITE   = 3'd1,
    PAT_R2W     = 3'd2,
    PAT_W2R     = 3'd3,
    PAT_REFRESH = 3'd4
  } pat_e;

  typedef enum logic [1:0] {
    LAST_REF = 2'd0,
    LAST_RD  = 2'd1,
    LAST_WR  = 2'd2
  } last_e;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic due
);
  localparam int CNT_W = $clog2(INTERVAL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due   <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      due   <= 1'b0;
    end else if (!due) begin
      if (cnt_q == CNT_W'(INTERVAL - 1)) due <= 1'b1;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pattern_gen.sv
module sdram_pattern_gen
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BURSTS    = 2,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 2,
  parameter int BURST_GAP = 4,
  parameter int T_TAIL    = 3,
  parameter int W2R_LEN   = 5,
  parameter int R2W_LEN   = 3,
  parameter int REF_LEN   = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pat_e              start_kind,
  input  logic [ROW_W-1:0]  start_row,
  input  logic [COL_W-1:0]  start_col,
  output logic              pat_busy,
  output logic              pat_last,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PRE_OFS  = T_RCD + (BURSTS - 1) * BURST_GAP + T_TAIL;
  localparam int SLOT_LEN = PRE_OFS + 1;
  localparam int LEN_A    = (SLOT_LEN > REF_LEN) ? SLOT_LEN : REF_LEN;
  localparam int LEN_B    = (W2R_LEN > R2W_LEN) ? W2R_LEN : R2W_LEN;
  localparam int MAX_LEN  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int OFS_W    = $clog2(MAX_LEN);

  pat_e              kind_q;
  logic              busy_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              is_access;
  logic              slot_end;
  logic              end_c;

  assign is_access = (kind_q == PAT_READ) || (kind_q == PAT_WRITE);
  assign slot_end  = (ofs_q == OFS_W'(SLOT_LEN - 1));

  always_comb begin
    case (kind_q)
      PAT_READ, PAT_WRITE: end_c = slot_end && (bank_q == BANK_W'(NUM_BANKS - 1));
      PAT_R2W:             end_c = (ofs_q == OFS_W'(R2W_LEN - 1));
      PAT_W2R:             end_c = (ofs_q == OFS_W'(W2R_LEN - 1));
      default:             end_c = (ofs_q == OFS_W'(REF_LEN - 1));
    endcase
  end

  assign pat_busy = busy_q;
  assign pat_last = busy_q && end_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= PAT_REFRESH;
      bank_q <= '0;
      ofs_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      kind_q <= start_kind;
      bank_q <= '0;
      ofs_q  <= '0;
      row_q  <= start_row;
      col_q  <= start_col;
    end else if (pat_last) begin
      busy_q <= 1'b0;
      ofs_q  <= '0;
      bank_q <= '0;
    end else if (busy_q) begin
      if (is_access && slot_end) begin
        ofs_q  <= '0;
        bank_q <= bank_q + 1'b1;
      end else begin
        ofs_q <= ofs_q + 1'b1;
      end
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = bank_q;
    addr_o = '0;
    if (busy_q) begin
      if (is_access) begin
        if (ofs_q == '0) begin
          cmd_o  = CMD_ACT;
          addr_o = ADDR_W'(row_q);
        end else if (ofs_q == OFS_W'(PRE_OFS)) begin
          cmd_o = CMD_PRE;
        end else begin
          for (int k = 0; k < BURSTS; k++) begin
            if (ofs_q == OFS_W'(T_RCD + k * BURST_GAP)) begin
              cmd_o  = (kind_q == PAT_WRITE) ? CMD_WR : CMD_RD;
              addr_o = ADDR_W'(col_q + COL_W'(k * BURST_LEN));
            end
          end
        end
      end else if ((kind_q == PAT_REFRESH) && (ofs_q == '0)) begin
        cmd_o = CMD_REF;
      end
    end
    if ((cmd_o == CMD_NOP) || (cmd_o == CMD_REF)) bank_o = '0;
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             pat_busy,
  input  logic             pat_last,
  input  logic             ref_due,
  output logic             ref_clear,
  output logic             start,
  output pat_e             start_kind,
  output logic [ROW_W-1:0] start_row,
  output logic [COL_W-1:0] start_col
);
  logic             held_q;
  logic             held_wr_q;
  logic [ROW_W-1:0] held_row_q;
  logic [COL_W-1:0] held_col_q;
  last_e            last_q;
  logic             boundary;
  logic             accept;
  logic             turn;

  assign boundary  = !pat_busy || pat_last;
  assign req_ready = boundary && !held_q && !ref_due;
  assign turn      = (req_write && (last_q == LAST_RD)) ||
                     (!req_write && (last_q == LAST_WR));

  always_comb begin
    start      = 1'b0;
    start_kind = PAT_READ;
    start_row  = req_row;
    start_col  = req_col;
    ref_clear  = 1'b0;
    accept     = 1'b0;
    if (boundary) begin
      if (held_q) begin
        start      = 1'b1;
        start_kind = held_wr_q ? PAT_WRITE : PAT_READ;
        start_row  = held_row_q;
        start_col  = held_col_q;
      end else if (ref_due) begin
        start      = 1'b1;
        start_kind = PAT_REFRESH;
        ref_clear  = 1'b1;
      end else if (req_valid) begin
        start  = 1'b1;
        accept = 1'b1;
        if (turn) start_kind = req_write ? PAT_R2W : PAT_W2R;
        else      start_kind = req_write ? PAT_WRITE : PAT_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_wr_q  <= 1'b0;
      held_row_q <= '0;
      held_col_q <= '0;
      last_q     <= LAST_REF;
    end else begin
      if (accept && turn) begin
        held_q     <= 1'b1;
        held_wr_q  <= req_write;
        held_row_q <= req_row;
        held_col_q <= req_col;
      end else if (start && held_q) begin
        held_q <= 1'b0;
      end
      if (start) begin
        case (start_kind)
          PAT_READ:    last_q <= LAST_RD;
          PAT_WRITE:   last_q <= LAST_WR;
          PAT_REFRESH: last_q <= LAST_REF;
          default:     last_q <= last_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_pattern_seq.sv
module sdram_pattern_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int BURSTS       = 2,
  parameter int BURST_LEN    = 8,
  parameter int T_RCD        = 2,
  parameter int BURST_GAP    = 4,
  parameter int T_TAIL       = 3,
  parameter int W2R_LEN      = 5,
  parameter int R2W_LEN      = 3,
  parameter int REF_LEN      = 8,
  parameter int REF_INTERVAL = 1560,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              pat_done
);
  logic             ref_due;
  logic             ref_clear;
  logic             start;
  pat_e             start_kind;
  logic [ROW_W-1:0] start_row;
  logic [COL_W-1:0] start_col;
  logic             pat_busy;
  logic             pat_last;
  cmd_e             gen_cmd;

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ref_clear),
    .due   (ref_due)
  );

  sdram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_row    (req_row),
    .req_col    (req_col),
    .pat_busy   (pat_busy),
    .pat_last   (pat_last),
    .ref_due    (ref_due),
    .ref_clear  (ref_clear),
    .start      (start),
    .start_kind (start_kind),
    .start_row  (start_row),
    .start_col  (start_col)
  );

  sdram_pattern_gen #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .BURSTS    (BURSTS),
    .BURST_LEN (BURST_LEN),
    .T_RCD     (T_RCD),
    .BURST_GAP (BURST_GAP),
    .T_TAIL    (T_TAIL),
    .W2R_LEN   (W2R_LEN),
    .R2W_LEN   (R2W_LEN),
    .REF_LEN   (REF_LEN)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (start_kind),
    .start_row  (start_row),
    .start_col  (start_col),
    .pat_busy   (pat_busy),
    .pat_last   (pat_last),
    .cmd_o      (gen_cmd),
    .bank_o     (cmd_bank),
    .addr_o     (cmd_addr)
  );

  assign cmd      = gen_cmd;
  assign pat_done = pat_last;
endmodule

// File: rtl/sdram_pattern_seq_sva.sv
module sdram_pattern_seq_sva #(
  parameter int NB      = 4,
  parameter int BANK_W  = 2,
  parameter int W2R_LEN = 5,
  parameter int R2W_LEN = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              pat_done,
  input logic              req_valid,
  input logic              req_ready
);
  logic [NB-1:0] open_q;
  logic [NB-1:0] pre_mask;
  logic [7:0]    since_wr;
  logic [7:0]    since_rd;
  logic          wr_seen;
  logic          rd_seen;

  assign pre_mask = (cmd == 3'd4) ? (NB'(1) << cmd_bank) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= '0;
      since_wr <= '0;
      since_rd <= '0;
      wr_seen  <= 1'b0;
      rd_seen  <= 1'b0;
    end else begin
      if (cmd == 3'd1) open_q <= open_q | (NB'(1) << cmd_bank);
      if (cmd == 3'd4) open_q <= open_q & ~(NB'(1) << cmd_bank);
      if (cmd == 3'd3) begin since_wr <= '0; wr_seen <= 1'b1; end
      else if (since_wr != 8'hFF) since_wr <= since_wr + 1'b1;
      if (cmd == 3'd2) begin since_rd <= '0; rd_seen <= 1'b1; end
      else if (since_rd != 8'hFF) since_rd <= since_rd + 1'b1;
    end
  end

  p_reset_nop_r1: assert property (@(posedge clk) !rst_n |=> (cmd == 3'd0 && !pat_done));

  p_w2r_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 && wr_seen) |-> (int'(since_wr) >= W2R_LEN));

  p_r2w_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 && rd_seen) |-> (int'(since_rd) >= R2W_LEN));

  p_ref_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5) |-> (open_q == '0));

  p_accept_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ((open_q & ~pre_mask) == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_done |=> !pat_done);

  p_act_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> !open_q[cmd_bank]);

  p_pre_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |-> open_q[cmd_bank]);
endmodule

bind sdram_pattern_seq sdram_pattern_seq_sva #(
  .NB      (NUM_BANKS),
  .BANK_W  (BANK_W),
  .W2R_LEN (W2R_LEN),
  .R2W_LEN (R2W_LEN)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .cmd_bank  (cmd_bank),
  .pat_done  (pat_done),
  .req_valid (req_valid),
  .req_ready (req_ready)
);

// File: tb/sdram_pattern_seq_test.sv
`timescale 1ns/1ps
module sdram_pattern_seq_test;
  localparam int NB       = 4;
  localparam int ROW_W    = 13;
  localparam int COL_W    = 10;
  localparam int BURSTS   = 2;
  localparam int BL       = 8;
  localparam int RCD      = 2;
  localparam int GAP      = 4;
  localparam int TAIL     = 3;
  localparam int W2R      = 5;
  localparam int R2W      = 3;
  localparam int REFL     = 8;
  localparam int INTERVAL = 150;
  localparam int PRE_OFS  = RCD + (BURSTS - 1) * GAP + TAIL;
  localparam int SLOT     = PRE_OFS + 1;
  localparam int ACC_LEN  = NB * SLOT;
  localparam int NVEC     = 8;
  localparam int ADDR_W   = 13;

  // {write, row[12:0], col[9:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 13'h0005, 10'h000},
    {1'b0, 13'h0012, 10'h010},
    {1'b1, 13'h1ABC, 10'h020},
    {1'b1, 13'h0777, 10'h100},
    {1'b0, 13'h1FFF, 10'h3F0},
    {1'b1, 13'h0001, 10'h008},
    {1'b1, 13'h0AAA, 10'h3F8},
    {1'b0, 13'h0555, 10'h3F8}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [2:0]        cmd;
  logic [1:0]        cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;
  logic              pat_done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_pattern_seq #(
    .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .BURSTS(BURSTS), .BURST_LEN(BL),
    .T_RCD(RCD), .BURST_GAP(GAP), .T_TAIL(TAIL), .W2R_LEN(W2R), .R2W_LEN(R2W),
    .REF_LEN(REFL), .REF_INTERVAL(INTERVAL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .pat_done(pat_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present a request, wait for the transfer, leave at the first cycle of the pattern
  task automatic send(input bit w, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                      output int waited, output bit saw_ref);
    waited = 0; saw_ref = 1'b0;
    req_valid = 1'b1; req_write = w; req_row = row; req_col = col;
    while (!req_ready) begin
      if (cmd == 3'd5) saw_ref = 1'b1;
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_turn(input int len, input string tag);
    int bad = -1;
    for (int i = 0; i < len; i++) begin
      if (bad < 0 && (cmd != 3'd0 || pat_done != (i == len - 1) || req_ready)) bad = i;
      @(negedge clk);
    end
    check(bad < 0, tag, bad, -1);
  endtask

  task automatic check_access(input bit w, input logic [ROW_W-1:0] row,
                              input logic [COL_W-1:0] col, input string tag);
    int bad = -1;
    int act_c = 0;
    int exp_c = 0;
    for (int i = 0; i < ACC_LEN; i++) begin
      int b = i / SLOT;
      int o = i % SLOT;
      int ec = 0;
      logic [ADDR_W-1:0] ea = '0;
      bit ok;
      if (o == 0) begin ec = 1; ea = ADDR_W'(row); end
      else if (o == PRE_OFS) ec = 4;
      for (int k = 0; k < BURSTS; k++)
        if (o == RCD + k * GAP) begin
          ec = w ? 3 : 2;
          ea = ADDR_W'(COL_W'(col + COL_W'(k * BL)));
        end
      ok = (int'(cmd) == ec) && (pat_done == (i == ACC_LEN - 1));
      if (ec != 0 && int'(cmd_bank) != b) ok = 1'b0;
      if (ec == 0 && cmd_bank != 2'd0) ok = 1'b0;
      if ((ec == 1 || ec == 2 || ec == 3) && cmd_addr != ea) ok = 1'b0;
      if (i != ACC_LEN - 1 && req_ready) ok = 1'b0;
      if (!ok && bad < 0) begin bad = i; act_c = int'(cmd); exp_c = ec; end
      if (i != ACC_LEN - 1) @(negedge clk);
    end
    check(bad < 0, $sformatf("%s access cycle %0d cmd", tag, bad), act_c, exp_c);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int last_m = 0; // 0 refresh/reset, 1 read, 2 write
    int waited;
    bit saw_ref;
    int t_ref0, t_ref1, t_done;
    int n_ref;
    int ctr;

    repeat (3) @(negedge clk);
    check(cmd == 3'd0 && !pat_done, "R1 cmd during reset", int'(cmd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd == 3'd0, "R1 cmd after reset", int'(cmd), 0);
    check(!pat_done, "R1 pat_done after reset", int'(pat_done), 0);
    check(req_ready, "R1 req_ready after reset", int'(req_ready), 1);

    for (int v = 0; v < NVEC; v++) begin
      bit w = VEC[v][23];
      logic [ROW_W-1:0] row = VEC[v][22:10];
      logic [COL_W-1:0] col = VEC[v][9:0];
      int sw = 0;
      send(w, row, col, waited, saw_ref);
      if (saw_ref) last_m = 0;
      if (w && last_m == 1) sw = R2W;
      else if (!w && last_m == 2) sw = W2R;
      if (!saw_ref)
        check(waited == 0, $sformatf("R3 R7 vec %0d accepted on boundary", v), waited, 0);
      if (sw > 0) check_turn(sw, $sformatf("R4 vec %0d turnaround", v));
      check_access(w, row, col,
        $sformatf("%s vec %0d", saw_ref ? "R2 R6" : "R2 R3", v));
      last_m = w ? 2 : 1;
    end

    // idle: measure refresh spacing and length
    n_ref = 0; t_ref0 = -1; t_ref1 = -1; t_done = -1; ctr = 0;
    for (int c = 0; c < 2 * INTERVAL + 40; c++) begin
      @(negedge clk);
      ctr++;
      if (cmd == 3'd5) begin
        if (n_ref == 0) t_ref0 = ctr; else if (n_ref == 1) t_ref1 = ctr;
        n_ref++;
      end
      if (pat_done && n_ref == 1 && t_done < 0) t_done = ctr;
    end
    check(n_ref >= 2, "R5 refresh issued while idle", n_ref, 2);
    check(t_ref1 - t_ref0 == INTERVAL + 1, "R5 refresh period", t_ref1 - t_ref0, INTERVAL + 1);
    check(t_done - t_ref0 == REFL - 1, "R5 R8 refresh pattern length", t_done - t_ref0, REFL - 1);

    // last access was a read; after the refresh a write needs no turnaround
    send(1'b1, 13'h0123, 10'h040, waited, saw_ref);
    check_access(1'b1, 13'h0123, 10'h040, "R6 write after refresh");
    send(1'b0, 13'h0321, 10'h080, waited, saw_ref);
    if (saw_ref) check_access(1'b0, 13'h0321, 10'h080, "R6 read after refresh");
    else begin
      check_turn(W2R, "R4 directed write-to-read");
      check_access(1'b0, 13'h0321, 10'h080, "R2 R4 read after turnaround");
    end
    @(negedge clk);
    check(cmd == 3'd0 && !pat_done, "R8 idle after last pattern", int'(cmd), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule